// File: doc/BRIEF.md
# Timer Compare-Match Output Controller

This block pairs a free-running up-counter with a set of compare channels. Each channel holds a compare value, a 2-bit action code and one output state bit. The state bit drives a pin directly. When the counter arrives at a channel's compare value, the channel applies its action to the state bit: hold, force low, force high or invert. The state bit is therefore a waveform generator, and not a sticky flag.

Software reaches every piece of state through a word-addressed port with a write enable, an address and write data. Word 0 is the control word, which packs the state bits and the action codes. Words 1 to 4 hold the compare values. Word 5 returns the counter and cannot be written. Reads are combinational from the address. A match fires once, for the cycle in which the counter has just stepped onto the compare value. A counter that is parked on that value does not fire it again.

Top module: `cmpout_timer`

## Requirements
- R1: After reset the counter, every compare value, every action code and every state bit read back as zero, and `match_out` is low.
- R2: The counter, read at word 5, rises by one on each clock edge at which `count_en` is high and keeps its value while `count_en` is low.
- R3: The counter wraps from all-ones to zero. A channel whose compare value is zero fires when the counter wraps to zero.
- R4: In the control word (word 0), bit i is the state bit of channel i, and bits 4+2i and 5+2i hold the action code of channel i. Bits 31:12 read as zero. Words 1 to 4 hold the compare values of channels 0 to 3, truncated to the counter width and returned zero-extended.
- R5: Action code 00 leaves the state bit unchanged on a match.
- R6: Action code 01 forces the state bit to 0 on a match, and code 10 forces it to 1.
- R7: Action code 11 inverts the state bit exactly once per match event. A counter that stays on the compare value causes no further inversions.
- R8: The state bit changes on the clock edge that ends the first cycle in which the counter shows the compare value. It still holds its old value during that cycle.
- R9: Channels that match in the same cycle all update on the same clock edge.
- R10: When a write to the control word and a match with a non-zero action code reach the same channel on the same edge, the match result wins. The other bits take the written values.
- R11: Writes to word 5 and to unmapped words 6 and 7 change nothing, and reads of unmapped words return zero.
- R12: `match_out[i]` equals the state bit of channel i in positive logic, so 1 drives the pin high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_en | input | 1 | Counter advance enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (3) | Word address |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data for `addr`, combinational |
| match_out | output | NUM_CH (4) | Channel state bits driven to pins |

## Verification
The hardest case to reach is the collision in which a software write to the control word lands on the same edge as a match action. The stimulus sets up the channels with the counter stopped, then raises `count_en` on a falling edge. It counts exactly as many edges as the compare value and holds the write strobe across the one edge that applies the match. Counter wrap needs 2^CNT_W cycles, so the bench builds the block with a 10-bit counter. At that width a wrap and a zero-compare match fall within a short run.

// File: rtl/cmpout_pkg.sv
package cmpout_pkg;

   localparam int ACT_W = 2;

   typedef enum logic [ACT_W-1:0] {
      ACT_KEEP  = 2'b00,
      ACT_CLEAR = 2'b01,
      ACT_SET   = 2'b10,
      ACT_FLIP  = 2'b11
   } match_act_e;

   // next value of a state bit under a given action
   function automatic logic act_apply(input match_act_e act, input logic cur);
      logic nxt;
      case (act)
         ACT_CLEAR: nxt = 1'b0;
         ACT_SET:   nxt = 1'b1;
         ACT_FLIP:  nxt = ~cur;
         default:   nxt = cur;
      endcase
      return nxt;
   endfunction

endpackage

// File: rtl/cmpout_counter.sv
module cmpout_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             count_en,
   output logic [CNT_W-1:0] cnt_o,
   output logic             fresh_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             fresh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         fresh_q <= 1'b0;
      end else begin
         // fresh marks a cycle whose counter value was just stepped into
         fresh_q <= count_en;
         if (count_en) cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign cnt_o   = cnt_q;
   assign fresh_o = fresh_q;

   // R2
   a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !count_en |=> $stable(cnt_o));

   // R2
   a_r2_fresh_tracks_en: assert property (@(posedge clk) disable iff (!rst_n)
      count_en |=> (fresh_o && !$stable(cnt_o)));

   // R3
   a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (count_en && (&cnt_o)) |=> (cnt_o == '0));

endmodule

// File: rtl/cmpout_channel.sv
module cmpout_channel
   import cmpout_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             fresh_i,
   input  logic             cmp_we,
   input  logic [CNT_W-1:0] cmp_wdata,
   input  logic             ctl_we,
   input  logic [ACT_W-1:0] act_wdata,
   input  logic             st_wdata,
   output logic [CNT_W-1:0] cmp_o,
   output logic [ACT_W-1:0] act_o,
   output logic             state_o
);

   logic [CNT_W-1:0] cmp_q;
   match_act_e       act_q;
   logic             state_q;
   logic             hit;
   logic             act_live;

   assign hit      = fresh_i && (cnt_i == cmp_q);
   assign act_live = hit && (act_q != ACT_KEEP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q   <= '0;
         act_q   <= ACT_KEEP;
         state_q <= 1'b0;
      end else begin
         if (cmp_we) cmp_q <= cmp_wdata;
         if (ctl_we) act_q <= match_act_e'(act_wdata);
         // a live match action takes priority over a software write
         if (act_live)    state_q <= act_apply(act_q, state_q);
         else if (ctl_we) state_q <= st_wdata;
      end
   end

   assign cmp_o   = cmp_q;
   assign act_o   = act_q;
   assign state_o = state_q;

   // R5
   a_r5_keep_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (fresh_i && cnt_i == cmp_o && act_o == 2'b00 && !ctl_we) |=> $stable(state_o));

   // R6
   a_r6_clear_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
      (fresh_i && cnt_i == cmp_o && act_o == 2'b01) |=> !state_o);

   // R6
   a_r6_set_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
      (fresh_i && cnt_i == cmp_o && act_o == 2'b10) |=> state_o);

   // R7
   a_r7_flip_inverts: assert property (@(posedge clk) disable iff (!rst_n)
      (fresh_i && cnt_i == cmp_o && act_o == 2'b11) |=> (state_o != $past(state_o)));

   // R7
   a_r7_no_stale_match: assert property (@(posedge clk) disable iff (!rst_n)
      (!fresh_i && !ctl_we) |=> $stable(state_o));

endmodule

// File: rtl/cmpout_timer.sv
module cmpout_timer
   import cmpout_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int NUM_CH = 4,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              count_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [NUM_CH-1:0] match_out
);

   localparam int CTL_ADDR  = 0;
   localparam int CMP_BASE  = 1;
   localparam int CNT_ADDR  = CMP_BASE + NUM_CH;
   localparam int FIELD_LSB = NUM_CH;
   localparam int CTL_USED  = NUM_CH * (1 + ACT_W);

   if (NUM_CH < 1) begin : g_bad_ch
      $error("cmpout_timer: NUM_CH must be at least 1");
   end
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("cmpout_timer: CNT_W must lie in 2..DATA_W");
   end
   if (CTL_USED > DATA_W) begin : g_bad_ctl
      $error("cmpout_timer: control word does not fit DATA_W");
   end
   if ((1 << ADDR_W) <= CNT_ADDR) begin : g_bad_addr
      $error("cmpout_timer: ADDR_W too small for the register map");
   end

   logic [CNT_W-1:0] cnt;
   logic             fresh;
   logic [CNT_W-1:0] cmp_val  [NUM_CH];
   logic [ACT_W-1:0] act_code [NUM_CH];
   logic [NUM_CH-1:0] state_bits;
   logic             ctl_we;
   logic [DATA_W-1:0] ctl_word;

   cmpout_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .count_en (count_en),
      .cnt_o    (cnt),
      .fresh_o  (fresh)
   );

   assign ctl_we = wr_en && (addr == ADDR_W'(CTL_ADDR));

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic cmp_we;
      assign cmp_we = wr_en && (addr == ADDR_W'(CMP_BASE + ch));

      cmpout_channel #(.CNT_W(CNT_W)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .cnt_i     (cnt),
         .fresh_i   (fresh),
         .cmp_we    (cmp_we),
         .cmp_wdata (wdata[CNT_W-1:0]),
         .ctl_we    (ctl_we),
         .act_wdata (wdata[FIELD_LSB + ACT_W*ch +: ACT_W]),
         .st_wdata  (wdata[ch]),
         .cmp_o     (cmp_val[ch]),
         .act_o     (act_code[ch]),
         .state_o   (state_bits[ch])
      );
   end

   always_comb begin
      ctl_word = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         ctl_word[i] = state_bits[i];
         ctl_word[FIELD_LSB + ACT_W*i +: ACT_W] = act_code[i];
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(CTL_ADDR)) begin
         rdata = ctl_word;
      end else if (addr == ADDR_W'(CNT_ADDR)) begin
         rdata = DATA_W'(cnt);
      end else begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(CMP_BASE + i)) rdata = DATA_W'(cmp_val[i]);
         end
      end
   end

   assign match_out = state_bits;

   // R11
   a_r11_counter_read_only: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(CNT_ADDR) && !count_en) |=> (rdata == $past(rdata) || addr != ADDR_W'(CNT_ADDR)));

   // R1
   a_r1_outputs_low_after_reset: assert property (@(posedge clk)
      !rst_n |=> (match_out == '0));

endmodule

// File: tb/sim_cmpout_timer.sv
module sim_cmpout_timer;

   localparam int CLK_PERIOD = 10;
   localparam int TB_CNT_W   = 10;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        count_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  match_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmpout_timer #(.CNT_W(TB_CNT_W), .NUM_CH(4), .DATA_W(32), .ADDR_W(3)) u0 (
      .clk(clk), .rst_n(rst_n), .count_en(count_en), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .match_out(match_out)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0; count_en = 1'b0; wr_en = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic reg_write(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = 3'(a); wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_read(input int a, output logic [31:0] d);
      @(negedge clk);
      addr = 3'(a);
      #1 d = rdata;
   endtask

   task automatic run_count(input int n);
      @(negedge clk);
      count_en = 1'b1;
      repeat (n) @(negedge clk);
      count_en = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      apply_reset();
      for (int a = 0; a < 6; a++) begin
         reg_read(a, d);
         check("R1 register zero after reset", d, 32'h0);
      end
      check("R1 match_out low after reset", 32'(match_out), 32'h0);
   endtask

   task automatic t_count_and_ignored();
      logic [31:0] d;
      apply_reset();
      run_count(5);
      reg_read(5, d);
      check("R2 counter after 5 enabled edges", d, 32'd5);
      repeat (4) @(negedge clk);
      reg_read(5, d);
      check("R2 counter holds while disabled", d, 32'd5);
      reg_write(5, 32'h123);
      reg_write(6, 32'hFFFF_FFFF);
      reg_write(7, 32'hFFFF_FFFF);
      reg_read(5, d);
      check("R11 counter write ignored", d, 32'd5);
      reg_read(6, d);
      check("R11 unmapped read zero", d, 32'h0);
      reg_read(0, d);
      check("R11 control unaffected by stray writes", d, 32'h0);
      check("R11 pins unaffected by stray writes", 32'(match_out), 32'h0);
   endtask

   task automatic t_layout();
      logic [31:0] d;
      apply_reset();
      // state 0101, ch0 code 11, ch1 code 10, ch2 code 01, ch3 code 00
      reg_write(0, 32'hFFFF_F1B5);
      reg_read(0, d);
      check("R4 control word layout", d, 32'h0000_01B5);
      check("R12 pins follow state bits", 32'(match_out), 32'h5);
      reg_write(1, 32'hFFFF_FC07);
      reg_write(2, 32'h0000_0155);
      reg_write(3, 32'h0000_02AA);
      reg_write(4, 32'h0000_03FF);
      reg_read(1, d);
      check("R4 compare 0 truncated", d, 32'h007);
      reg_read(2, d);
      check("R4 compare 1", d, 32'h155);
      reg_read(3, d);
      check("R4 compare 2", d, 32'h2AA);
      reg_read(4, d);
      check("R4 compare 3", d, 32'h3FF);
   endtask

   task automatic t_actions();
      logic [31:0] d;
      apply_reset();
      // state 0011; codes ch0 keep, ch1 clear, ch2 set, ch3 flip
      reg_write(0, 32'h0000_0E43);
      for (int a = 1; a < 5; a++) reg_write(a, 32'd4);
      @(negedge clk);
      count_en = 1'b1;
      repeat (4) @(negedge clk);
      addr = 3'd5;
      #1 check("R8 counter shows compare value", rdata, 32'd4);
      check("R8 state unchanged during matching cycle", 32'(match_out), 32'h3);
      @(negedge clk);
      count_en = 1'b0;
      check("R9 all channels updated on one edge", 32'(match_out), 32'hD);
      repeat (5) @(negedge clk);
      reg_read(0, d);
      check("R5 keep channel unchanged", 32'(d[0]), 32'h1);
      check("R6 clear and set channels", 32'(d[2:1]), 32'h2);
   endtask

   task automatic t_toggle_once();
      apply_reset();
      reg_write(0, 32'h0000_0030);
      reg_write(1, 32'd3);
      run_count(3);
      repeat (10) @(negedge clk);
      check("R7 single inversion while counter parked", 32'(match_out), 32'h1);
      run_count(2);
      check("R7 no inversion past compare value", 32'(match_out), 32'h1);
   endtask

   task automatic t_wrap();
      logic [31:0] d;
      apply_reset();
      reg_write(0, 32'h0000_00F0);
      reg_write(1, 32'd0);
      reg_write(2, 32'h3FF);
      run_count(1023);
      reg_read(5, d);
      check("R3 counter at all-ones", d, 32'h3FF);
      check("R3 only all-ones channel fired", 32'(match_out), 32'h2);
      run_count(1);
      reg_read(5, d);
      check("R3 counter wrapped to zero", d, 32'h0);
      check("R3 zero compare fires on wrap", 32'(match_out), 32'h3);
   endtask

   task automatic t_collide();
      logic [31:0] d;
      apply_reset();
      reg_write(0, 32'h0000_0011);
      reg_write(1, 32'd3);
      @(negedge clk);
      count_en = 1'b1;
      repeat (3) @(negedge clk);
      wr_en = 1'b1; addr = 3'd0; wdata = 32'h0000_0013;
      @(negedge clk);
      wr_en = 1'b0; count_en = 1'b0;
      reg_read(0, d);
      check("R10 match beats write, other bits written", d, 32'h0000_0012);
      check("R10 pins after collision", 32'(match_out), 32'h2);
   endtask

   initial begin
      t_reset();
      t_count_and_ignored();
      t_layout();
      t_actions();
      t_toggle_once();
      t_wrap();
      t_collide();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule